// File: doc/BRIEF.md
# Page-Erase Nonvolatile Byte Store Controller

This block fronts a byte-addressed nonvolatile store of 1024 bytes, mapped at addresses 0xF800 to 0xFBFF and held in on-chip registers. It applies flash-style write rules. A byte can be programmed only while it holds the erased value 0xFF. The only way to return bytes to 0xFF is to erase a whole 32-byte page. A page erase needs both the erase command code 0xFE and an erase-enable configuration bit. The system supplies that bit from bit 2 of its configuration register at address 0x90.

Requests arrive on three independent strobes: a byte write, a byte read and a command. Programming and erasing keep the block busy for a fixed number of cycles, both set by parameters. Any in-range request that arrives during that time is refused. Rejected operations set a sticky error flag, which software clears by strobing a status read. Addresses outside the window belong to other blocks and are silently ignored.

When several strobes arrive in one cycle, only one is handled. The erase command wins over the write, and the write wins over the read. The losing strobes are dropped without any error.

Top module: `nvpage_ctrl`

## Requirements
- R1: After reset the outputs are `busy`=0, `err`=0 and `rd_valid`=0, and every byte in the window reads 0xFF.
- R2: An in-range read while idle raises `rd_valid` for one cycle, one clock after the request. In that cycle `rd_data` carries the stored byte.
- R3: A write to a byte that reads 0xFF is accepted. `busy` is high for exactly PROG_CYCLES cycles, starting the cycle after the request, and the byte then reads back the written data.
- R4: A write to a byte that does not read 0xFF leaves the byte unchanged. It sets `err` on the next clock and does not raise `busy`.
- R5: A command with code 0xFE, an in-range address and `cfg_erase_en`=1 keeps `busy` high for exactly ERASE_CYCLES cycles. It then sets to 0xFF all 32 bytes of the page selected by address bits [9:5] relative to 0xF800. Other pages are left untouched.
- R6: An erase command (0xFE) while `cfg_erase_en`=0 changes no byte, does not raise `busy`, and sets `err`.
- R7: A command with any code other than 0xFE has no effect: no busy, no error and no change to the store.
- R8: An in-range read, write or erase request that arrives while `busy` is high is refused. It produces no `rd_valid`, changes no byte and sets `err`.
- R9: Requests whose address lies outside 0xF800..0xFBFF are ignored. They cause no `busy`, no `err` and no `rd_valid`.
- R10: `err` stays set until a cycle with `status_rd`=1 and clears on the following clock. If a new error occurs in that same cycle, `err` stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_req | input | 1 | Byte write strobe |
| wr_addr | input | 16 | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_req | input | 1 | Byte read strobe |
| rd_addr | input | 16 | Byte read address |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code (0xFE = page erase) |
| cmd_addr | input | 16 | Any address inside the page to erase |
| cfg_erase_en | input | 1 | Erase-enable configuration bit |
| status_rd | input | 1 | Status read strobe, clears the error flag |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Program or erase in progress |
| err | output | 1 | Sticky flag for rejected operations |

## Verification
A read result and the error flag for a refused request are both registered once. They appear one clock after the request edge, so the bench drives each strobe on a falling edge, drops it on the next falling edge, and samples `rd_valid`, `rd_data` and `err` there. Busy starts one clock after an accepted request and lasts exactly the programmed latency. The bench counts busy-high falling edges and compares the count with PROG_CYCLES or ERASE_CYCLES. Store contents are only read back after busy has fallen, because the commit happens on the edge that ends the busy window.

// File: rtl/nvp_pkg.sv
package nvp_pkg;

  // Kind of long-running operation held in the pending slot
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } nvp_op_e;

endpackage

// File: rtl/nvp_rst_sync.sv
module nvp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/nvp_addr_dec.sv
module nvp_addr_dec #(
  parameter int              ADDR_W    = 16,
  parameter logic [15:0]     BASE_ADDR = 16'hF800,
  parameter int              IDX_W     = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - ADDR_W'(BASE_ADDR);
    hit    = (addr >= ADDR_W'(BASE_ADDR)) && (offset[ADDR_W-1:IDX_W] == '0);
    idx    = offset[IDX_W-1:0];
  end

endmodule

// File: rtl/nvp_busy_timer.sv
module nvp_busy_timer #(
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_erase,
  output logic busy,
  output logic done
);

  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_en;

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    cnt_en = 1'b0;
    if (start_erase) begin
      cnt_en = 1'b1;
      cnt_d  = ERASE_LOAD;
      busy_d = 1'b1;
    end else if (start_prog) begin
      cnt_en = 1'b1;
      cnt_d  = PROG_LOAD;
      busy_d = 1'b1;
    end else if (done) begin
      cnt_en = 1'b1;
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  // New work is only started while the timer is idle (R8)
  assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |-> !busy_q);

  // Busy cannot end before the counter has run down (R3, R5)
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);

endmodule

// File: rtl/nvp_array.sv
module nvp_array #(
  parameter int DATA_W     = 8,
  parameter int NUM_PAGES  = 32,
  parameter int PAGE_BYTES = 32
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     prog_en,
  input  logic                                     erase_en,
  input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0]  wr_idx,
  input  logic [DATA_W-1:0]                        wr_data,
  input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0]  rda_idx,
  output logic [DATA_W-1:0]                        rda_data,
  input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0]  rdb_idx,
  output logic [DATA_W-1:0]                        rdb_data
);

  localparam int TOTAL  = NUM_PAGES * PAGE_BYTES;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = IDX_W - OFF_W;

  logic [TOTAL-1:0][DATA_W-1:0] cells;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic [PAGE_BYTES-1:0][DATA_W-1:0] row_q, row_d;
    logic                              page_sel;
    logic                              row_en;

    assign page_sel = (wr_idx[IDX_W-1:OFF_W] == PAGE_W'(p));
    assign row_en   = (prog_en || erase_en) && page_sel;

    always_comb begin
      row_d = row_q;
      if (erase_en) begin
        row_d = '1;
      end else if (prog_en) begin
        row_d[wr_idx[OFF_W-1:0]] = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '1;
      end else if (row_en) begin
        row_q <= row_d;
      end
    end

    assign cells[p*PAGE_BYTES +: PAGE_BYTES] = row_q;
  end

  assign rda_data = cells[rda_idx];
  assign rdb_data = cells[rdb_idx];

  // Programming only ever lands on an erased byte (R4)
  assert_prog_erased_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> (cells[wr_idx] == '1));

  // One commit kind per cycle (R5)
  assert_one_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_en && erase_en));

endmodule

// File: rtl/nvpage_ctrl.sv
module nvpage_ctrl #(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 8,
  parameter logic [15:0] BASE_ADDR    = 16'hF800,
  parameter int          NUM_PAGES    = 32,
  parameter int          PAGE_BYTES   = 32,
  parameter int          PROG_CYCLES  = 4,
  parameter int          ERASE_CYCLES = 10,
  parameter logic [7:0]  ERASE_CODE   = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cfg_erase_en,
  input  logic              status_rd,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              err
);

  import nvp_pkg::*;

  localparam int TOTAL = NUM_PAGES * PAGE_BYTES;
  localparam int IDX_W = $clog2(TOTAL);

  logic             rst_i_n;
  logic             wr_hit, rd_hit, cmd_hit;
  logic [IDX_W-1:0] wr_idx, rd_idx, cmd_idx;
  logic [DATA_W-1:0] wr_cur, rd_cur;
  logic             busy_w, done_w;
  logic             erase_cmd;
  logic             start_prog, start_erase, rd_fire, err_set;

  // Pending operation slot
  logic [IDX_W-1:0]  pend_idx_q, pend_idx_d;
  logic [DATA_W-1:0] pend_data_q, pend_data_d;
  nvp_op_e           pend_op_q, pend_op_d;
  logic              pend_en;

  // Output registers
  logic              rd_valid_q, rd_valid_d;
  logic [DATA_W-1:0] rd_data_q, rd_data_d;
  logic              rd_data_en;
  logic              err_q, err_d;

  nvp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  nvp_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) u_dec_wr (
    .addr(wr_addr), .hit(wr_hit), .idx(wr_idx)
  );
  nvp_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) u_dec_rd (
    .addr(rd_addr), .hit(rd_hit), .idx(rd_idx)
  );
  nvp_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) u_dec_cmd (
    .addr(cmd_addr), .hit(cmd_hit), .idx(cmd_idx)
  );

  nvp_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_i_n),
    .start_prog(start_prog), .start_erase(start_erase),
    .busy(busy_w), .done(done_w)
  );

  nvp_array #(.DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk(clk), .rst_n(rst_i_n),
    .prog_en(done_w && (pend_op_q == OP_PROG)),
    .erase_en(done_w && (pend_op_q == OP_ERASE)),
    .wr_idx(pend_idx_q), .wr_data(pend_data_q),
    .rda_idx(wr_idx), .rda_data(wr_cur),
    .rdb_idx(rd_idx), .rdb_data(rd_cur)
  );

  assign erase_cmd = cmd_valid && (cmd_code == ERASE_CODE) && cmd_hit;

  // Request arbitration: erase command, then write, then read
  always_comb begin
    start_prog  = 1'b0;
    start_erase = 1'b0;
    rd_fire     = 1'b0;
    err_set     = 1'b0;
    if (erase_cmd) begin
      if (busy_w || !cfg_erase_en) err_set = 1'b1;
      else                         start_erase = 1'b1;
    end else if (wr_req && wr_hit) begin
      if (busy_w || (wr_cur != '1)) err_set = 1'b1;
      else                          start_prog = 1'b1;
    end else if (rd_req && rd_hit) begin
      if (busy_w) err_set = 1'b1;
      else        rd_fire = 1'b1;
    end
  end

  // Next state of the pending slot and the output registers
  always_comb begin
    pend_en     = start_prog || start_erase;
    pend_idx_d  = start_erase ? cmd_idx : wr_idx;
    pend_data_d = wr_data;
    pend_op_d   = start_erase ? OP_ERASE : OP_PROG;
    rd_valid_d  = rd_fire;
    rd_data_en  = rd_fire;
    rd_data_d   = rd_cur;
    if (err_set)        err_d = 1'b1;
    else if (status_rd) err_d = 1'b0;
    else                err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pend_idx_q  <= '0;
      pend_data_q <= '0;
      pend_op_q   <= OP_PROG;
    end else if (pend_en) begin
      pend_idx_q  <= pend_idx_d;
      pend_data_q <= pend_data_d;
      pend_op_q   <= pend_op_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      rd_valid_q <= rd_valid_d;
      err_q      <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_data_q <= '0;
    end else if (rd_data_en) begin
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign busy     = busy_w;
  assign err      = err_q;

  // Read data only follows an idle read request (R2)
  assert_rd_after_req_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_valid_q |-> $past(rd_req && !busy_w));

  // An erase is only launched with the enable bit set (R6)
  assert_erase_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    start_erase |-> cfg_erase_en);

  // Errors only come from in-range requests (R9)
  assert_err_src_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(err_q) |-> $past((wr_req && wr_hit) || (rd_req && rd_hit) || (cmd_valid && cmd_hit)));

  // Status read clears the flag when no new error coincides (R10)
  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (status_rd && !err_set) |=> !err_q);

endmodule

// File: tb/tb_nvpage_ctrl.sv
module tb_nvpage_ctrl;

  localparam int PROG_CYC  = 4;
  localparam int ERASE_CYC = 10;
  localparam int NVEC      = 24;

  // op: 0 read, 1 write, 2 erase (code 0xFE), 3 status read
  // {op[1:0], addr[15:0], data[7:0], erase_en, exp_err, exp_read[7:0]}
  localparam logic [35:0] VEC [NVEC] = '{
    {2'd0, 16'hF800, 8'h00, 1'b0, 1'b0, 8'hFF},
    {2'd1, 16'hF800, 8'hAA, 1'b0, 1'b0, 8'h00},
    {2'd0, 16'hF800, 8'h00, 1'b0, 1'b0, 8'hAA},
    {2'd1, 16'hF800, 8'h55, 1'b0, 1'b1, 8'h00},
    {2'd0, 16'hF800, 8'h00, 1'b0, 1'b1, 8'hAA},
    {2'd3, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00},
    {2'd0, 16'hF81F, 8'h00, 1'b0, 1'b0, 8'hFF},
    {2'd1, 16'hF81F, 8'h3C, 1'b0, 1'b0, 8'h00},
    {2'd1, 16'hF820, 8'h77, 1'b0, 1'b0, 8'h00},
    {2'd2, 16'hF800, 8'h00, 1'b0, 1'b1, 8'h00},
    {2'd0, 16'hF800, 8'h00, 1'b0, 1'b1, 8'hAA},
    {2'd3, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00},
    {2'd2, 16'hF805, 8'h00, 1'b1, 1'b0, 8'h00},
    {2'd0, 16'hF800, 8'h00, 1'b0, 1'b0, 8'hFF},
    {2'd0, 16'hF81F, 8'h00, 1'b0, 1'b0, 8'hFF},
    {2'd0, 16'hF820, 8'h00, 1'b0, 1'b0, 8'h77},
    {2'd1, 16'hF800, 8'h55, 1'b0, 1'b0, 8'h00},
    {2'd0, 16'hF800, 8'h00, 1'b0, 1'b0, 8'h55},
    {2'd1, 16'hFBFF, 8'h99, 1'b0, 1'b0, 8'h00},
    {2'd0, 16'hFBFF, 8'h00, 1'b0, 1'b0, 8'h99},
    {2'd2, 16'hFBE0, 8'h00, 1'b1, 1'b0, 8'h00},
    {2'd0, 16'hFBFF, 8'h00, 1'b0, 1'b0, 8'hFF},
    {2'd0, 16'hF820, 8'h00, 1'b0, 1'b0, 8'h77},
    {2'd0, 16'hF800, 8'h00, 1'b0, 1'b0, 8'h55}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_req, rd_req, cmd_valid, cfg_erase_en, status_rd;
  logic [15:0] wr_addr, rd_addr, cmd_addr;
  logic [7:0]  wr_data, cmd_code;
  logic        rd_valid, busy, err;
  logic [7:0]  rd_data;

  int n_checks = 0;
  int n_fails  = 0;
  logic       got_v;
  logic [7:0] got_d;

  always #4 clk = ~clk;

  nvpage_ctrl #(.PROG_CYCLES(PROG_CYC), .ERASE_CYCLES(ERASE_CYC)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cfg_erase_en(cfg_erase_en), .status_rd(status_rd),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .err(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_req = 0; rd_req = 0; cmd_valid = 0; status_rd = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // Drive one operation for one cycle, capture the registered response
  task automatic do_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                       input logic en);
    @(negedge clk);
    cfg_erase_en = en;
    case (op)
      2'd0: begin rd_req = 1; rd_addr = a; end
      2'd1: begin wr_req = 1; wr_addr = a; wr_data = d; end
      2'd2: begin cmd_valid = 1; cmd_code = 8'hFE; cmd_addr = a; end
      default: status_rd = 1;
    endcase
    @(negedge clk);
    idle_inputs();
    got_v = rd_valid;
    got_d = rd_data;
    wait_idle();
  endtask

  task automatic read_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    do_op(2'd0, a, 8'h00, 1'b0);
    check(req, {31'd0, got_v}, 32'd1);
    check(req, {24'd0, got_d}, {24'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int n;
    idle_inputs();
    wr_addr = 0; rd_addr = 0; cmd_addr = 0; wr_data = 0; cmd_code = 0;
    cfg_erase_en = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 err", {31'd0, err}, 32'd0);
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    read_chk("R1 erased 0xFBC7", 16'hFBC7, 8'hFF);

    // Vector table: R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NVEC; i++) begin
      do_op(VEC[i][35:34], VEC[i][33:18], VEC[i][17:10], VEC[i][9]);
      check($sformatf("R4/R6/R10 err vec %0d", i), {31'd0, err}, {31'd0, VEC[i][8]});
      if (VEC[i][35:34] == 2'd0) begin
        check($sformatf("R2 rd_valid vec %0d", i), {31'd0, got_v}, 32'd1);
        check($sformatf("R2/R3/R5 data vec %0d", i), {24'd0, got_d}, {24'd0, VEC[i][7:0]});
      end
    end

    // R3 busy length for a program
    @(negedge clk);
    wr_req = 1; wr_addr = 16'hF900; wr_data = 8'h12;
    @(negedge clk);
    idle_inputs();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R3 busy cycles", n, PROG_CYC);

    // R5 busy length for an erase
    @(negedge clk);
    cfg_erase_en = 1; cmd_valid = 1; cmd_code = 8'hFE; cmd_addr = 16'hF91F;
    @(negedge clk);
    idle_inputs();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R5 busy cycles", n, ERASE_CYC);
    read_chk("R5 erased 0xF900", 16'hF900, 8'hFF);

    // R8 requests while busy
    @(negedge clk);
    wr_req = 1; wr_addr = 16'hF840; wr_data = 8'h5A;
    @(negedge clk);
    idle_inputs();
    rd_req = 1; rd_addr = 16'hF800;
    @(negedge clk);
    idle_inputs();
    check("R8 no rd_valid when busy", {31'd0, rd_valid}, 32'd0);
    check("R8 err when busy", {31'd0, err}, 32'd1);
    wr_req = 1; wr_addr = 16'hF860; wr_data = 8'h11;
    @(negedge clk);
    idle_inputs();
    wait_idle();
    read_chk("R8 refused write left 0xFF", 16'hF860, 8'hFF);
    read_chk("R3 accepted write", 16'hF840, 8'h5A);
    do_op(2'd3, 16'h0, 8'h0, 1'b0);
    check("R10 cleared", {31'd0, err}, 32'd0);

    // R9 out-of-range requests
    do_op(2'd0, 16'hF7FF, 8'h00, 1'b0);
    check("R9 read below window", {31'd0, got_v}, 32'd0);
    do_op(2'd0, 16'hFC00, 8'h00, 1'b0);
    check("R9 read above window", {31'd0, got_v}, 32'd0);
    @(negedge clk);
    wr_req = 1; wr_addr = 16'hFC00; wr_data = 8'h01;
    @(negedge clk);
    idle_inputs();
    check("R9 write busy", {31'd0, busy}, 32'd0);
    @(negedge clk);
    cfg_erase_en = 1; cmd_valid = 1; cmd_code = 8'hFE; cmd_addr = 16'h0090;
    @(negedge clk);
    idle_inputs();
    check("R9 erase busy", {31'd0, busy}, 32'd0);
    check("R9 err", {31'd0, err}, 32'd0);

    // R7 other command codes
    @(negedge clk);
    cfg_erase_en = 1; cmd_valid = 1; cmd_code = 8'hFD; cmd_addr = 16'hF800;
    @(negedge clk);
    idle_inputs();
    check("R7 busy", {31'd0, busy}, 32'd0);
    check("R7 err", {31'd0, err}, 32'd0);
    read_chk("R7 page kept", 16'hF800, 8'h55);

    // R10 new error coinciding with status read keeps the flag
    @(negedge clk);
    wr_req = 1; wr_addr = 16'hF800; wr_data = 8'h00; status_rd = 1;
    @(negedge clk);
    idle_inputs();
    check("R10 set wins", {31'd0, err}, 32'd1);
    read_chk("R4 programmed byte kept", 16'hF800, 8'h55);
    do_op(2'd3, 16'h0, 8'h0, 1'b0);
    check("R10 cleared again", {31'd0, err}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule